// File: doc/BRIEF.md
# Video Sync Reference Timing Measurer

This block measures the timing of an incoming video sync reference. Horizontal, vertical and frame sync strobes, already synchronised to the 27 MHz sample clock, are counted against that clock. The results are held in five read-only 16-bit measurement registers. The horizontal registers hold the line period in clocks and the span of sixteen line periods. That span is fine enough to separate nominal rates from their 1/1.001 variants. The vertical registers hold the lines per vertical interval and the lines across two vertical intervals. A fifth register holds the lines per frame interval.

A tracker waits until two consecutive line periods agree within one clock and then declares the reference acquired. It drops the lock when the period wanders further than that, or when no line pulse arrives for 65535 clocks. The results survive a lost reference. When a reference is acquired, the horizontal results are rewritten only if the new line period differs from the stored one. The vertical results are rewritten only if the new line count per vertical interval differs from the stored count. A host reads the results through a plain combinational word-address port.

Top module: `sync_ref_meter`

## Requirements
- R1: Word address 0x0A reads the line period: the number of clocks from one horizontal strobe to the next, captured on the strobe that acquires the reference.
- R2: The reference is acquired on a horizontal strobe whose period differs by at most 1 from the period just before it. Periods that differ by more never acquire. A locked period that deviates from the stored one by more than 1 drops the lock.
- R3: Word address 0x0B reads the clocks spanned by the 16 line periods that follow the acquiring strobe.
- R4: Word address 0x0C reads the horizontal strobes counted over the first full vertical interval after acquisition. A horizontal strobe in the same cycle as a vertical strobe belongs to the interval that the vertical strobe opens.
- R5: Word address 0x0D reads the horizontal strobes counted over the two vertical intervals that follow the one measured for R4.
- R6: Word address 0x0E reads the horizontal strobes between the first two frame strobes after acquisition.
- R7: If no frame strobe arrives before the 4th vertical strobe after acquisition, address 0x0E reads zero.
- R8: After 65535 clocks without a horizontal strobe the reference is lost, and all five registers keep their values.
- R9: On acquisition with a line period equal to the stored one, addresses 0x0A and 0x0B are not rewritten. A new 16-period span is measured only when the period changed.
- R10: Every measurement saturates at 0xFFFF instead of wrapping.
- R11: Addresses 0x00 to 0x09 and every address above 0x0E read zero.
- R12: After reset, all five measurement registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_pulse | input | 1 | Horizontal sync strobe, one cycle, active high |
| vs_pulse | input | 1 | Vertical sync strobe, one cycle, active high |
| fs_pulse | input | 1 | Frame sync strobe, one cycle, active high |
| rd_addr | input | 8 | Register word address |
| rd_data | output | 16 | Register contents at rd_addr, combinational |

## Verification
The bench walks a set of references. Each one has a different line period, vertical length and frame length, and each is switched in while the previous one is still locked. A design that failed to drop and reacquire would keep stale results. A frameless reference must clear the frame count, while a stuck design would keep the previous one. A long silence must leave every register untouched. A design that cleared on loss would read zero there.

The same line period is then reapplied with one-clock jitter. A design that re-measured on every acquisition would change the 16-period span from 48 to 56. A very long line period must pin the span at 0xFFFF rather than wrap to a small value. A prelude of disagreeing periods must never produce a lock.

// File: rtl/sync_ref_meter.sv
module sync_ref_meter #(
  parameter int W          = 16,
  parameter int AW         = 8,
  parameter int TOL        = 1,
  parameter int SPAN       = 16,
  parameter int FS_WAIT    = 4,
  parameter int LOSS_LIMIT = 65535
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_pulse,
  input  logic          vs_pulse,
  input  logic          fs_pulse,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  localparam logic [W-1:0]  TOLV  = W'(TOL);
  localparam logic [W-1:0]  LOSS  = W'(LOSS_LIMIT);
  localparam logic [W-1:0]  MAXV  = '1;
  localparam int            SIW   = $clog2(SPAN);
  localparam int            FVW   = $clog2(FS_WAIT + 1);
  localparam logic [AW-1:0] A_HP  = AW'(8'h0A);
  localparam logic [AW-1:0] A_H16 = AW'(8'h0B);
  localparam logic [AW-1:0] A_V   = AW'(8'h0C);
  localparam logic [AW-1:0] A_V2  = AW'(8'h0D);
  localparam logic [AW-1:0] A_F   = AW'(8'h0E);

  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] x);
    return (x == MAXV) ? x : x + 1'b1;
  endfunction

  function automatic logic [W-1:0] absdiff(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  logic [W-1:0]   hcnt, cand, hreg, h16reg, scnt;
  logic [W-1:0]   lcnt, vreg, v2reg, v2cnt, fcnt, freg;
  logic           hseen, cand_ok, locked;
  logic           sarm, vstart, vdone, v2arm, v2half, fstart, fdone;
  logic [SIW-1:0] sidx;
  logic [FVW-1:0] fvs;

  wire timed_out = hcnt >= LOSS;
  wire acq       = hs_pulse && !locked && hseen && cand_ok && !timed_out &&
                   (absdiff(hcnt, cand) <= TOLV);
  wire drop      = locked && (timed_out || (hs_pulse && absdiff(hcnt, hreg) > TOLV));
  wire hnew      = hcnt != hreg;
  wire live      = locked && !drop;

  // Line period tracking and acquisition
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt    <= '0;
      hseen   <= 1'b0;
      cand    <= '0;
      cand_ok <= 1'b0;
      locked  <= 1'b0;
      hreg    <= '0;
    end else begin
      hcnt <= hs_pulse ? W'(1) : sat_inc(hcnt);
      if (hs_pulse) begin
        hseen   <= 1'b1;
        cand_ok <= hseen && !timed_out;
        cand    <= hcnt;
      end else if (timed_out) begin
        hseen   <= 1'b0;
        cand_ok <= 1'b0;
      end
      if (acq) begin
        locked <= 1'b1;
        if (hnew) hreg <= hcnt;
      end else if (drop) begin
        locked <= 1'b0;
      end
    end
  end

  // Sixteen-period span
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scnt   <= '0;
      sidx   <= '0;
      sarm   <= 1'b0;
      h16reg <= '0;
    end else begin
      scnt <= acq ? W'(1) : sat_inc(scnt);
      if (acq) begin
        sarm <= hnew;
        sidx <= '0;
      end else if (drop) begin
        sarm <= 1'b0;
      end else if (sarm && hs_pulse) begin
        if (sidx == SIW'(SPAN - 1)) begin
          h16reg <= scnt;
          sarm   <= 1'b0;
        end else begin
          sidx <= sidx + 1'b1;
        end
      end
    end
  end

  // Vertical line counts
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcnt   <= '0;
      v2cnt  <= '0;
      vreg   <= '0;
      v2reg  <= '0;
      vstart <= 1'b0;
      vdone  <= 1'b0;
      v2arm  <= 1'b0;
      v2half <= 1'b0;
    end else begin
      if (vs_pulse)      lcnt <= hs_pulse ? W'(1) : '0;
      else if (hs_pulse) lcnt <= sat_inc(lcnt);

      if (vs_pulse && live && vstart && !vdone) v2cnt <= hs_pulse ? W'(1) : '0;
      else if (hs_pulse)                        v2cnt <= sat_inc(v2cnt);

      if (acq) begin
        vstart <= 1'b0;
        vdone  <= 1'b0;
        v2arm  <= 1'b0;
      end else if (drop) begin
        v2arm <= 1'b0;
      end else if (live && vs_pulse) begin
        if (!vstart) begin
          vstart <= 1'b1;
        end else if (!vdone) begin
          vdone <= 1'b1;
          if (lcnt != vreg) begin
            vreg   <= lcnt;
            v2arm  <= 1'b1;
            v2half <= 1'b0;
          end
        end else if (v2arm) begin
          if (!v2half) begin
            v2half <= 1'b1;
          end else begin
            v2reg <= v2cnt;
            v2arm <= 1'b0;
          end
        end
      end
    end
  end

  // Frame line count and frame-absence timeout
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt   <= '0;
      freg   <= '0;
      fstart <= 1'b0;
      fdone  <= 1'b0;
      fvs    <= '0;
    end else begin
      if (fs_pulse)      fcnt <= hs_pulse ? W'(1) : '0;
      else if (hs_pulse) fcnt <= sat_inc(fcnt);

      if (acq) begin
        fstart <= 1'b0;
        fdone  <= 1'b0;
        fvs    <= '0;
      end else if (live && !fdone) begin
        if (fs_pulse) begin
          if (!fstart) begin
            fstart <= 1'b1;
          end else begin
            freg  <= fcnt;
            fdone <= 1'b1;
          end
        end else if (vs_pulse && !fstart) begin
          if (fvs == FVW'(FS_WAIT - 1)) begin
            freg  <= '0;
            fdone <= 1'b1;
          end else begin
            fvs <= fvs + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_HP:    rd_data = hreg;
      A_H16:   rd_data = h16reg;
      A_V:     rd_data = vreg;
      A_V2:    rd_data = v2reg;
      A_F:     rd_data = freg;
      default: rd_data = '0;
    endcase
  end

  assert_hreg_on_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_pulse |=> $stable(hreg));
  assert_lock_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(hs_pulse));
  assert_span_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> $stable(h16reg));
  assert_vert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> ($stable(vreg) && $stable(v2reg) && $stable(freg)));
  assert_loss_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !hs_pulse && hcnt >= LOSS) |=> !locked);
  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == MAXV && !hs_pulse) |=> hcnt == MAXV);
endmodule

// File: tb/tb_sync_ref_meter.sv
module tb_sync_ref_meter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hs_pulse = 1'b0, vs_pulse = 1'b0, fs_pulse = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sync_ref_meter dut (.clk(clk), .rst_n(rst_n), .hs_pulse(hs_pulse), .vs_pulse(vs_pulse),
                      .fs_pulse(fs_pulse), .rd_addr(rd_addr), .rd_data(rd_data));

  // {line period, lines per vertical, lines per frame (0 = none)}
  localparam int NV = 5;
  localparam logic [47:0] VEC [NV] = '{
    {16'd20, 16'd10, 16'd20},
    {16'd40, 16'd8,  16'd0 },
    {16'd25, 16'd12, 16'd12},
    {16'd33, 16'd6,  16'd12},
    {16'd3,  16'd5,  16'd10}
  };

  task automatic chk(input string req, input logic [7:0] a, input logic [15:0] exp);
    rd_addr = a;
    #1;
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s addr %h actual %h expected %h", req, a, rd_data, exp);
    end
  endtask

  task automatic line(input bit v, input bit f, input int len);
    @(negedge clk);
    hs_pulse = 1'b1; vs_pulse = v; fs_pulse = f;
    @(negedge clk);
    hs_pulse = 1'b0; vs_pulse = 1'b0; fs_pulse = 1'b0;
    repeat (len - 2) @(negedge clk);
  endtask

  task automatic run_ref(input int p, input int l, input int f, input int n, input bit jit);
    for (int i = 0; i < n; i++)
      line((l != 0) && (i % l == 0), (f != 0) && (i % f == 0),
           (jit && (i % 2 == 0)) ? p + 1 : p);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    for (int a = 8'h0A; a <= 8'h0E; a++) chk("R12", 8'(a), 16'h0000);

    // R2: periods 10,20,30,40 never agree, no lock, 0x0A stays zero
    line(0, 0, 10); line(0, 0, 20); line(0, 0, 30); line(0, 0, 40); line(0, 0, 50);
    chk("R2", 8'h0A, 16'h0000);

    // Table walk: R1 R3 R4 R5 R6 R7, each vector reacquires (R2)
    for (int k = 0; k < NV; k++) begin
      int p, l, f, s;
      p = int'(VEC[k][47:32]); l = int'(VEC[k][31:16]); f = int'(VEC[k][15:0]);
      run_ref(p, l, f, 5 * l + 3 * f + 24, 1'b0);
      @(negedge clk);
      s = (16 * p > 65535) ? 65535 : 16 * p;
      chk("R1", 8'h0A, 16'(p));
      chk("R3", 8'h0B, 16'(s));
      chk("R4", 8'h0C, 16'(l));
      chk("R5", 8'h0D, 16'(2 * l));
      chk(f == 0 ? "R7" : "R6", 8'h0E, 16'(f));
    end

    // R11 reserved and unmapped reads
    chk("R11", 8'h00, 16'h0000);
    chk("R11", 8'h09, 16'h0000);
    chk("R11", 8'h0F, 16'h0000);
    chk("R11", 8'hFF, 16'h0000);

    // R8: silence longer than the loss limit, all results kept
    repeat (66000) @(negedge clk);
    chk("R8", 8'h0A, 16'd3);
    chk("R8", 8'h0B, 16'd48);
    chk("R8", 8'h0C, 16'd5);
    chk("R8", 8'h0D, 16'd10);
    chk("R8", 8'h0E, 16'd10);

    // R9: reacquire at period 3 with one-clock jitter (4,3,4,3...)
    run_ref(3, 5, 10, 60, 1'b1);
    @(negedge clk);
    chk("R9", 8'h0A, 16'd3);
    chk("R9", 8'h0B, 16'd48);
    chk("R9", 8'h0C, 16'd5);
    chk("R9", 8'h0E, 16'd10);

    // R10: 16 x 4100 exceeds 16 bits, span saturates
    run_ref(4100, 0, 0, 20, 1'b0);
    @(negedge clk);
    chk("R10", 8'h0A, 16'd4100);
    chk("R10", 8'h0B, 16'hFFFF);

    finish_run();
  end
endmodule